// File: doc/BRIEF.md
# Low-Side Switch PWM Channel with Fault Latching

This block drives one low-side power switch with a pulse-width-modulated command. A slow timing strobe, nominally 2 MHz, advances a 20-bit counter, so period and on-time are set in 500 ns steps and the slowest period is about half a second. The switch closes when each period starts and opens once the on-time count runs out. An on-time of zero keeps the switch permanently open. An on-time equal to or longer than the period keeps it permanently closed. New period and on-time settings take effect only at a period boundary, so a change in the middle of a period never produces a runt pulse.

The power stage reports two conditions. A short report counts only while the switch is commanded closed. It latches a short flag and forces the switch open until software clears the flag. That clear is refused while the PWM pattern still calls for the switch to be closed. An open-load report counts only while the switch is open. It latches an open flag that has no effect on the drive. The same clear input releases it, and the flag sets again if the load is still open.

Top module: `lsd_pwm_chan`

## Requirements
- R1: After reset the switch command is open (`sw_close`=0), and both `short_lat` and `open_lat` are 0.
- R2: While `chan_en` is 0, `sw_close` is 0 in the same cycle. The counter restarts at the first count of a period, and the settings are loaded continuously.
- R3: With 0 < width < period, once enabled `sw_close` is 1 for the first `width` strobes of each period and 0 for the remaining `period - width` strobes. The pattern repeats every `period` strobes.
- R4: The counter advances only in clock cycles where `tick` is 1. Cycles without `tick` leave the output pattern where it was.
- R5: A width of 0 keeps `sw_close` at 0 throughout.
- R6: A width greater than or equal to the period keeps `sw_close` at 1 throughout. A period of 0 with a nonzero width also counts as this case.
- R7: Values on `per_cfg` and `wid_cfg` are taken only at the strobe that ends a period, or while disabled. A period already running finishes with its old settings.
- R8: `short_det` is sampled only at clock edges where `sw_close` is 1. When sampled high, `short_lat` becomes 1 after that edge, and `sw_close` stays 0 for as long as `short_lat` is 1.
- R9: `flt_clr` clears `short_lat` only at an edge where the PWM pattern does not call for the switch to be closed (disabled, or in the off part of the period). At other edges the request is ignored.
- R10: `open_det` is sampled only at edges where `sw_close` is 0, and sets `open_lat` after that edge. `open_lat` never alters `sw_close`.
- R11: `flt_clr` clears `open_lat`. If `open_det` is sampled high at the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing strobe; the counter advances one step per cycle in which this is high |
| chan_en | input | 1 | Channel enable; 0 holds the switch open |
| per_cfg | input | 20 | Period in strobes |
| wid_cfg | input | 20 | On-time in strobes |
| flt_clr | input | 1 | Clear request for both fault flags |
| short_det | input | 1 | Short-circuit report from the power stage |
| open_det | input | 1 | Open-load report from the power stage |
| sw_close | output | 1 | Switch command, 1 = closed |
| short_lat | output | 1 | Latched short-circuit flag |
| open_lat | output | 1 | Latched open-load flag |

## Verification
`sw_close` is a combinational function of `chan_en` and the registered counter, shadow settings and short flag. A change of `chan_en` is therefore visible in the same cycle. A new counter position is visible one clock after the edge that carries a strobe. Both fault flags change one clock after the edge that samples the report or the clear, and a short forces the switch open from that same cycle.

The bench drives inputs at the falling edge. It counts strobed rising edges since the last enable to get the period position, and it compares all outputs at the next falling edge against a pattern computed from that position, the period and the width. This keeps every expected value on the cycle where the result is due.

// File: rtl/lsd_pwm_pkg.sv
package lsd_pwm_pkg;

   // Default counter width: 20 bits of 500 ns strobes.
   localparam int unsigned LSD_CNT_W = 20;

   // Level the PWM pattern asks for at a given counter position,
   // including the steady-off and steady-on extremes.
   function automatic logic pwm_level(input logic [31:0] cnt,
                                      input logic [31:0] per,
                                      input logic [31:0] wid);
      if (wid == 32'd0)       return 1'b0;
      else if (wid >= per)    return 1'b1;
      else                    return (cnt < wid);
   endfunction

endpackage

// File: rtl/lsd_pwm_timer.sv
module lsd_pwm_timer
   import lsd_pwm_pkg::*;
#(
   parameter int unsigned CNT_W = LSD_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] wid_in,
   output logic             level,
   output logic [CNT_W-1:0] wid_sh
);

   localparam int unsigned PAD_W = 32 - CNT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] wid_q;
   logic             last_step;

   // End of period: the final count, or a period too short to count.
   assign last_step = (per_q <= CNT_W'(1)) || (cnt_q >= per_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         wid_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
         per_q <= per_in;
         wid_q <= wid_in;
      end else if (tick) begin
         if (last_step) begin
            cnt_q <= '0;
            per_q <= per_in;
            wid_q <= wid_in;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign level = pwm_level(cnt_q, per_q, wid_q);
      end else begin : g_pad
         assign level = pwm_level({{PAD_W{1'b0}}, cnt_q},
                                  {{PAD_W{1'b0}}, per_q},
                                  {{PAD_W{1'b0}}, wid_q});
      end
   endgenerate

   assign wid_sh = wid_q;

endmodule

// File: rtl/lsd_short_latch.sv
module lsd_short_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_now,
   input  logic demand,
   input  logic det,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (sw_now && det)
         flag <= 1'b1;
      else if (clr && !demand)
         flag <= 1'b0;
   end

endmodule

// File: rtl/lsd_open_mon.sv
module lsd_open_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_now,
   input  logic det,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (!sw_now && det)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end

endmodule

// File: rtl/lsd_pwm_chan.sv
module lsd_pwm_chan
   import lsd_pwm_pkg::*;
#(
   parameter int unsigned CNT_W = LSD_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             chan_en,
   input  logic [CNT_W-1:0] per_cfg,
   input  logic [CNT_W-1:0] wid_cfg,
   input  logic             flt_clr,
   input  logic             short_det,
   input  logic             open_det,
   output logic             sw_close,
   output logic             short_lat,
   output logic             open_lat
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("lsd_pwm_chan: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             level;
   logic             demand;
   logic [CNT_W-1:0] wid_sh;

   lsd_pwm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .run    (chan_en),
      .per_in (per_cfg),
      .wid_in (wid_cfg),
      .level  (level),
      .wid_sh (wid_sh)
   );

   assign demand   = chan_en & level;
   assign sw_close = demand & ~short_lat;

   lsd_short_latch u_short (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_now (sw_close),
      .demand (demand),
      .det    (short_det),
      .clr    (flt_clr),
      .flag   (short_lat)
   );

   lsd_open_mon u_open (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_now (sw_close),
      .det    (open_det),
      .clr    (flt_clr),
      .flag   (open_lat)
   );

endmodule

// File: rtl/lsd_pwm_chan_chk.sv
module lsd_pwm_chan_chk #(
   parameter int unsigned CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_en,
   input logic             flt_clr,
   input logic             short_det,
   input logic             open_det,
   input logic             sw_close,
   input logic             short_lat,
   input logic             open_lat,
   input logic             demand,
   input logic [CNT_W-1:0] wid_sh
);

   p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> !sw_close);

   p_zero_width_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wid_sh == '0) |-> !sw_close);

   p_short_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_close && short_det) |=> short_lat);

   p_short_forces_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      short_lat |-> !sw_close);

   p_clear_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (short_lat && demand) |=> short_lat);

   p_open_ignored_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_lat && sw_close) |=> !open_lat);

   p_open_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (open_lat && !flt_clr) |=> open_lat);

endmodule

bind lsd_pwm_chan lsd_pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_en   (chan_en),
   .flt_clr   (flt_clr),
   .short_det (short_det),
   .open_det  (open_det),
   .sw_close  (sw_close),
   .short_lat (short_lat),
   .open_lat  (open_lat),
   .demand    (demand),
   .wid_sh    (wid_sh)
);

// File: tb/lsd_pwm_chan_tb.sv
module lsd_pwm_chan_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic          chan_en = 1'b0;
   logic [CW-1:0] per_cfg = '0;
   logic [CW-1:0] wid_cfg = '0;
   logic          flt_clr = 1'b0;
   logic          short_det = 1'b0;
   logic          open_det = 1'b0;
   logic          sw_close;
   logic          short_lat;
   logic          open_lat;

   int n_chk = 0;
   int n_bad = 0;
   int k = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsd_pwm_chan #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
      .per_cfg(per_cfg), .wid_cfg(wid_cfg), .flt_clr(flt_clr),
      .short_det(short_det), .open_det(open_det),
      .sw_close(sw_close), .short_lat(short_lat), .open_lat(open_lat)
   );

   function automatic logic exp_on(int kk, int p, int w);
      if (w == 0) return 1'b0;
      if (w >= p) return 1'b1;
      return ((kk % p) < w);
   endfunction

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b (k=%0d, t=%0t)", req, act, exp, k, $time);
      end
   endtask

   task automatic adv();
      logic t;
      @(posedge clk);
      t = tick;
      if (t) k++;
      @(negedge clk);
   endtask

   task automatic restart(int p, int w);
      chan_en = 1'b0;
      per_cfg = CW'(p);
      wid_cfg = CW'(w);
      @(negedge clk);
      @(negedge clk);
      chan_en = 1'b1;
      k = 0;
      #1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 sw_close", sw_close, 1'b0);
      chk("R1 short_lat", short_lat, 1'b0);
      chk("R1 open_lat", open_lat, 1'b0);
   endtask

   task automatic t_pattern(int p, int w, int n, string req);
      restart(p, w);
      chk(req, sw_close, exp_on(0, p, w));
      for (int i = 0; i < n; i++) begin
         adv();
         chk(req, sw_close, exp_on(k, p, w));
      end
   endtask

   task automatic t_disable();
      restart(4, 4);
      chk("R2 enabled on", sw_close, 1'b1);
      chan_en = 1'b0;
      #1;
      chk("R2 same cycle", sw_close, 1'b0);
      for (int i = 0; i < 3; i++) begin
         adv();
         chk("R2 held open", sw_close, 1'b0);
      end
   endtask

   task automatic t_tick();
      restart(3, 1);
      for (int i = 0; i < 18; i++) begin
         tick = (i % 3 == 0);
         adv();
         chk("R4 strobe only", sw_close, exp_on(k, 3, 1));
      end
      tick = 1'b1;
   endtask

   task automatic t_reload();
      restart(4, 2);
      adv();
      per_cfg = CW'(6);
      wid_cfg = CW'(3);
      chk("R7 old", sw_close, exp_on(k, 4, 2));
      while (k < 16) begin
         adv();
         if (k < 4) chk("R7 old kept", sw_close, exp_on(k, 4, 2));
         else       chk("R7 new taken", sw_close, exp_on(k - 4, 6, 3));
      end
   endtask

   task automatic t_short();
      restart(4, 2);
      // off phase (k%4==2): report must be ignored
      adv(); adv();
      short_det = 1'b1;
      adv();
      short_det = 1'b0;
      chk("R8 ignored while open", short_lat, 1'b0);
      adv();
      chk("R8 pattern", sw_close, exp_on(k, 4, 2));
      // k==4: on phase
      short_det = 1'b1;
      adv();
      short_det = 1'b0;
      chk("R8 latched", short_lat, 1'b1);
      chk("R8 forced open", sw_close, 1'b0);
      while (k < 8) begin
         adv();
         chk("R8 stays open", sw_close, 1'b0);
      end
      // k==8: pattern calls for closed -> clear refused
      flt_clr = 1'b1;
      adv();
      flt_clr = 1'b0;
      chk("R9 clear refused", short_lat, 1'b1);
      adv();
      // k==10: off phase -> clear accepted
      flt_clr = 1'b1;
      adv();
      flt_clr = 1'b0;
      chk("R9 clear accepted", short_lat, 1'b0);
      adv();
      chk("R9 resumes", sw_close, exp_on(k, 4, 2));
   endtask

   task automatic t_open();
      restart(4, 2);
      open_det = 1'b1;
      adv();
      chk("R10 ignored while closed", open_lat, 1'b0);
      adv();
      chk("R10 ignored while closed", open_lat, 1'b0);
      adv();
      chk("R10 latched", open_lat, 1'b1);
      while (k < 6) begin
         adv();
         chk("R10 drive unaffected", sw_close, exp_on(k, 4, 2));
      end
      // k==6, off, report still high: clear loses
      flt_clr = 1'b1;
      adv();
      flt_clr = 1'b0;
      chk("R11 set wins", open_lat, 1'b1);
      adv();
      // k==8, closed: clear succeeds
      flt_clr = 1'b1;
      adv();
      flt_clr = 1'b0;
      chk("R11 cleared", open_lat, 1'b0);
      adv(); adv();
      chk("R11 sets again", open_lat, 1'b1);
      open_det = 1'b0;
      flt_clr = 1'b1;
      adv();
      flt_clr = 1'b0;
      chk("R11 cleared after removal", open_lat, 1'b0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_disable();
      t_pattern(4, 2, 12, "R3 p4 w2");
      t_pattern(7, 3, 21, "R3 p7 w3");
      t_pattern(5, 1, 10, "R3 p5 w1");
      t_tick();
      t_pattern(6, 0, 12, "R5 zero width");
      t_pattern(5, 5, 10, "R6 width equals period");
      t_pattern(3, 9, 8, "R6 width above period");
      t_pattern(0, 2, 5, "R6 zero period");
      t_reload();
      t_short();
      t_open();
      finish_run();
   end

endmodule